// File: doc/BRIEF.md
# Drift-Compensated PTP Time Counter

This block keeps a 64-bit nanosecond time-of-day count that is clocked by a reference oscillator faster than the count's nominal rate. On every reference clock, a 32-bit fractional accumulator takes in a programmable addend. When that sum carries out, the time count moves forward by a programmable whole number of nanoseconds. The mean step rate is the oscillator frequency times addend / 2^32. Software trims the frequency in steps of parts per billion by rewriting the addend. The accumulator is never cleared on such a write.

Software reaches the block through a small word-addressed register port. The port holds:

- a control word with a 2-bit reference-select code, which is brought out for an external clock mux;
- the addend;
- the step period;
- two time words.

A read of the low time word latches the upper half, so that a later read of the high word belongs to the same instant. A time load writes the low word into a staging register and then the high word. The second write replaces the counter and clears the accumulator. Bus words are byte-reversed by default (big-endian register layout), and a parameter selects little-endian.

Top module: `ptp_tod_counter`

## Requirements
- R1: After reset the time count is 0, the step pulse is low, the select code is 1, the addend is ADDEND_RST (0x999999A4), the step period is PERIOD_RST (10) and the accumulator holds 0.
- R2: On each clock without a load, the accumulator becomes (accumulator + addend) mod 2^32. The step pulse tick_o is high for the cycle after an edge at which that sum carried out of bit 31.
- R3: At an edge where the sum carries, the time count increases by exactly the step period. At any other edge without a load it holds. It never moves by more than one period per clock.
- R4: An addend write is used from the next clock edge onward, and the accumulator residue is kept across it.
- R5: A write to the step period (word 2, low PERIOD_W bits) applies to the next step after the write edge.
- R6: A read of word 3 returns the live low 32 bits and latches the upper 32 bits. A read of word 4 returns the latched upper bits, even if the count has moved on since.
- R7: A write to word 3 only stages the low word and leaves the count unchanged. A write to word 4 loads {written word, staged word} into the count and clears the accumulator in the same edge, with no step at that edge.
- R8: Word 0 bits [1:0] hold the reference-select code (0 external timer clock, 1 system clock, 2 transmit/reserved clock, 3 RTC). The code drives clk_sel_o, and the upper bits read as zero.
- R9: With BIG_ENDIAN=1 (default), bus byte 0 (bits 7:0) maps to register bits 31:24, and so on, fully byte-reversed on both write and read data. With 0, there is no swap.
- R10: Words 5 to 7 read as zero, and writes to them change no register and no output.
- R11: Word 1 reads back the addend and word 2 the period, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Word address |
| reg_wdata_i | input | 32 | Write data (bus byte order) |
| reg_rdata_o | output | 32 | Read data, combinational from address (bus byte order) |
| time_ns_o | output | 64 | Nanosecond time-of-day count |
| tick_o | output | 1 | High for one cycle after each step |
| clk_sel_o | output | 2 | Reference-select code |

## Verification
A wrong accumulator residue shows up as a step pulse in the wrong cycle, or as a missing one. The bench compares the step pulse and the full time count against a behavioural model on every clock, so a residue error appears within the cycles it takes for the carry pattern to diverge. With an addend near 2^32 that is one or two clocks. A wrong snapshot or load shows at the register port on the very next read, or as a count mismatch on the cycle after the load edge. The addend sweep includes 0, 2^31 and 2^32-1, so the carry rate runs from never, through every other clock, to nearly every clock.

// File: rtl/ptp_tod_pkg.sv
`timescale 1ns/1ps
package ptp_tod_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL    = 3'd0,
    REG_ADDEND  = 3'd1,
    REG_PERIOD  = 3'd2,
    REG_TIME_LO = 3'd3,
    REG_TIME_HI = 3'd4
  } reg_addr_e;

  function automatic logic [31:0] bswap32(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction
endpackage

// File: rtl/ptp_phase_acc.sv
`timescale 1ns/1ps
module ptp_phase_acc #(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [ACC_W-1:0] addend_i,
  output logic             carry_o,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum     = {1'b0, acc_q} + {1'b0, addend_i};
  assign carry_o = sum[ACC_W];
  assign acc_o   = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else            acc_q <= sum[ACC_W-1:0];
  end

  p_wrap_add_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> acc_o == ACC_W'($past(acc_o) + $past(addend_i)));
  p_clear_on_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> acc_o == '0);
endmodule

// File: rtl/ptp_time_reg.sv
`timescale 1ns/1ps
module ptp_time_reg #(
  parameter int unsigned TIME_W   = 64,
  parameter int unsigned PERIOD_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [TIME_W-1:0]   load_val_i,
  input  logic                step_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic [TIME_W-1:0]   time_o,
  output logic                tick_o
);
  logic [TIME_W-1:0] time_q;
  logic              tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q <= '0;
      tick_q <= 1'b0;
    end else if (load_i) begin
      time_q <= load_val_i;
      tick_q <= 1'b0;
    end else begin
      if (step_i) time_q <= time_q + TIME_W'(period_i);
      tick_q <= step_i;
    end
  end

  assign time_o = time_q;
  assign tick_o = tick_q;

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(time_o));
  p_one_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && step_i) |=> (time_o - $past(time_o)) == TIME_W'($past(period_i)));
  p_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (time_o == $past(load_val_i)) && !tick_o);
endmodule

// File: rtl/ptp_regif.sv
`timescale 1ns/1ps
module ptp_regif
  import ptp_tod_pkg::*;
#(
  parameter int unsigned TIME_W     = 64,
  parameter int unsigned PERIOD_W   = 8,
  parameter logic [31:0] ADDEND_RST = 32'h9999_99A4,
  parameter int unsigned PERIOD_RST = 10,
  parameter bit          BIG_ENDIAN = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic                re_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic [TIME_W-1:0]   time_i,
  output logic [31:0]         addend_o,
  output logic [PERIOD_W-1:0] period_o,
  output logic [1:0]          clk_sel_o,
  output logic                load_o,
  output logic [TIME_W-1:0]   load_val_o
);
  localparam int unsigned HI_W = TIME_W - 32;

  logic [31:0]         wd, rd;
  logic [1:0]          sel_q;
  logic [31:0]         addend_q, lo_stage_q;
  logic [PERIOD_W-1:0] period_q;
  logic [HI_W-1:0]     snap_hi_q;

  generate
    if (BIG_ENDIAN) begin : g_swap
      assign wd      = bswap32(wdata_i);
      assign rdata_o = bswap32(rd);
    end else begin : g_plain
      assign wd      = wdata_i;
      assign rdata_o = rd;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q      <= 2'd1;
      addend_q   <= ADDEND_RST;
      period_q   <= PERIOD_W'(PERIOD_RST);
      lo_stage_q <= '0;
      snap_hi_q  <= '0;
    end else begin
      if (we_i) begin
        case (addr_i)
          REG_CTRL:    sel_q      <= wd[1:0];
          REG_ADDEND:  addend_q   <= wd;
          REG_PERIOD:  period_q   <= wd[PERIOD_W-1:0];
          REG_TIME_LO: lo_stage_q <= wd;
          default: ;
        endcase
      end
      if (re_i && addr_i == REG_TIME_LO) snap_hi_q <= time_i[TIME_W-1:32];
    end
  end

  always_comb begin
    case (addr_i)
      REG_CTRL:    rd = {30'd0, sel_q};
      REG_ADDEND:  rd = addend_q;
      REG_PERIOD:  rd = 32'(period_q);
      REG_TIME_LO: rd = time_i[31:0];
      REG_TIME_HI: rd = 32'(snap_hi_q);
      default:     rd = '0;
    endcase
  end

  assign load_o     = we_i && addr_i == REG_TIME_HI;
  assign load_val_o = {wd[HI_W-1:0], lo_stage_q};
  assign addend_o   = addend_q;
  assign period_o   = period_q;
  assign clk_sel_o  = sel_q;

  p_snapshot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == REG_TIME_LO) |=> snap_hi_q == $past(time_i[TIME_W-1:32]));
  p_sel_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_CTRL) |=> clk_sel_o == $past(wd[1:0]));
  p_unmapped_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i > REG_TIME_HI) |=> $stable(addend_o) && $stable(period_o) && $stable(clk_sel_o));
endmodule

// File: rtl/ptp_tod_counter.sv
`timescale 1ns/1ps
module ptp_tod_counter
  import ptp_tod_pkg::*;
#(
  parameter int unsigned TIME_W     = 64,
  parameter int unsigned ACC_W      = 32,
  parameter int unsigned PERIOD_W   = 8,
  parameter logic [31:0] ADDEND_RST = 32'h9999_99A4,
  parameter int unsigned PERIOD_RST = 10,
  parameter bit          BIG_ENDIAN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic [TIME_W-1:0] time_ns_o,
  output logic              tick_o,
  output logic [1:0]        clk_sel_o
);
  logic [31:0]         addend;
  logic [PERIOD_W-1:0] period;
  logic                load, carry;
  logic [TIME_W-1:0]   load_val;
  logic [ACC_W-1:0]    acc;

  ptp_regif #(
    .TIME_W(TIME_W), .PERIOD_W(PERIOD_W), .ADDEND_RST(ADDEND_RST),
    .PERIOD_RST(PERIOD_RST), .BIG_ENDIAN(BIG_ENDIAN)
  ) u_regif (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .re_i(reg_re_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .time_i(time_ns_o), .addend_o(addend), .period_o(period),
    .clk_sel_o(clk_sel_o), .load_o(load), .load_val_o(load_val)
  );

  ptp_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk_i, .rst_ni, .clr_i(load),
    .addend_i(addend[ACC_W-1:0]), .carry_o(carry), .acc_o(acc)
  );

  ptp_time_reg #(.TIME_W(TIME_W), .PERIOD_W(PERIOD_W)) u_time (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(load_val),
    .step_i(carry), .period_i(period), .time_o(time_ns_o), .tick_o(tick_o)
  );

  p_tick_carry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load && carry) |=> tick_o);
  p_residue_kept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == REG_ADDEND) |=> acc == ACC_W'($past(acc) + $past(addend[ACC_W-1:0])));
endmodule

// File: tb/test_ptp_tod_counter.sv
`timescale 1ns/1ps
module test_ptp_tod_counter;
  logic        clk_i = 0, rst_ni = 0;
  logic        reg_we_i = 0, reg_re_i = 0;
  logic [2:0]  reg_addr_i = 0;
  logic [31:0] reg_wdata_i = 0;
  logic [31:0] reg_rdata_o;
  logic [63:0] time_ns_o;
  logic        tick_o;
  logic [1:0]  clk_sel_o;

  int errors = 0, checks = 0, cycles = 0;
  string tag = "R1";

  ptp_tod_counter i_ptp_tod_counter (.*);

  always #10 clk_i = ~clk_i;

  // behavioural reference model (internal byte order)
  longint unsigned m_time, m_acc;
  logic [31:0] m_addend, m_lo, m_snap;
  logic [7:0]  m_period;
  logic [1:0]  m_sel;
  logic        m_tick;

  function automatic logic [31:0] sw(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_time = 0; m_acc = 0; m_addend = 32'h9999_99A4; m_lo = 0;
      m_snap = 0; m_period = 10; m_sel = 1; m_tick = 0;
    end else begin
      logic [31:0] wd;
      longint unsigned t0, s;
      wd = sw(reg_wdata_i);
      t0 = m_time;
      s  = m_acc + longint'(m_addend);
      if (reg_we_i && reg_addr_i == 4) begin
        m_time = {wd, m_lo}; m_acc = 0; m_tick = 0;
      end else begin
        m_tick = s >= 64'h1_0000_0000;
        if (m_tick) m_time = m_time + longint'(m_period);
        m_acc = s & 64'hFFFF_FFFF;
      end
      if (reg_re_i && reg_addr_i == 3) m_snap = t0[63:32];
      if (reg_we_i) case (reg_addr_i)
        0: m_sel = wd[1:0];
        1: m_addend = wd;
        2: m_period = wd[7:0];
        3: m_lo = wd;
        default: ;
      endcase
    end
  end

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    logic [31:0] r;
    case (a)
      0: r = {30'd0, m_sel};
      1: r = m_addend;
      2: r = {24'd0, m_period};
      3: r = m_time[31:0];
      4: r = m_snap;
      default: r = 0;
    endcase
    return sw(r);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // compare every clock, away from the edge
  always @(negedge clk_i) if (rst_ni) begin
    cycles++;
    chk({tag, " time"}, time_ns_o, m_time);
    chk({tag, " tick R2"}, {63'd0, tick_o}, {63'd0, m_tick});
    chk({tag, " sel"}, {62'd0, clk_sel_o}, {62'd0, m_sel});
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i); reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i); reg_we_i = 0;
  endtask

  task automatic rd(input string req, input logic [2:0] a);
    @(negedge clk_i); reg_re_i = 1; reg_addr_i = a;
    #1 chk(req, {32'd0, reg_rdata_o}, {32'd0, exp_rd(a)});
    @(negedge clk_i); reg_re_i = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    #35 rst_ni = 1;
    // R1 reset values
    #1 chk("R1 time", time_ns_o, 0);
    chk("R1 sel", {62'd0, clk_sel_o}, 64'd1);
    rd("R1 addend R11", 1);
    rd("R1 period R11", 2);
    rd("R1 ctrl", 0);
    tag = "R3"; idle(40);
    tag = "R4";
    wr(1, sw(32'hFFFF_FFFF)); idle(10);
    wr(1, sw(32'h8000_0000)); idle(10);
    wr(1, sw(32'h0000_0000)); idle(10);
    chk("R3 addend 0 no step", {63'd0, tick_o}, 0);
    wr(1, sw(32'h1234_5678)); idle(30);
    tag = "R5";
    wr(2, sw(32'd25)); rd("R5 period R11", 2); idle(20);
    tag = "R7";
    wr(3, sw(32'hDEAD_BEEF)); idle(5);
    wr(4, sw(32'h0000_0012)); idle(5);
    chk("R7 loaded hi", {32'd0, time_ns_o[63:32]}, 64'h12);
    // R6 snapshot across a low-word wrap
    tag = "R6";
    wr(1, sw(32'hFFFF_FFFF));
    wr(3, sw(32'hFFFF_FF80));
    wr(4, sw(32'h0000_0007));
    rd("R6 lo", 3);
    idle(12);
    chk("R6 hi moved", {32'd0, time_ns_o[63:32]}, 64'h8);
    rd("R6 hi snap", 4);
    rd("R6 lo2", 3); rd("R6 hi2", 4);
    tag = "R8";
    wr(0, 32'hFFFF_FFFF); rd("R8 ctrl", 0);
    chk("R8 sel3", {62'd0, clk_sel_o}, 64'd3);
    tag = "R9";
    wr(0, 32'h0200_0000);
    chk("R9 swapped sel", {62'd0, clk_sel_o}, 64'd2);
    wr(1, 32'h0102_0304); rd("R9 addend", 1);
    idle(10);
    tag = "R10";
    for (int a = 5; a < 8; a++) wr(3'(a), 32'hFFFF_FFFF);
    for (int a = 0; a < 8; a++) rd("R10 readback", 3'(a));
    idle(10);
    finish_run();
  end
endmodule